// File: doc/BRIEF.md
# OSD Serial Write Command Decoder

This block sits behind the byte receiver of an on-screen-display controller and turns a stream of received bytes into writes to the display register array. Each byte arrives with a one-cycle valid strobe. An active-low frame signal brackets each transaction. The decoder sorts every byte into one of three kinds: a row header, a column header or a payload byte. From these it produces a write address (row, column, and a plane bit that picks the code plane or the attribute plane), the write data and a single-cycle write strobe.

Two transfer styles exist. In the addressed style, each payload byte is preceded by a column header and, if needed, a row header. In the streaming style, entered through a column header with bit 6 set, every later byte of the transaction is payload. The address then steps forward after each write, through the last column and on into the next row. Streaming is one-way: only the end of the frame or a reset leaves it.

Top module: `osd_wcmd_dec`

## Requirements
- R1: A byte with bit 7 = 1 taken while a header is expected is a row header. Its bits 3..0 load the row, and its bit 5 loads the plane (0 = code plane, 1 = attribute plane). It causes no write.
- R2: A header byte with bit 7 = 0 is a column header. Its bits 4..0 load the column. Bit 6 = 0 selects the addressed style and bit 6 = 1 selects streaming. It causes no write.
- R3: In the addressed style, the single byte after a column header is payload, whatever its value. It is written to the current row, column and plane, with wr_en high in the cycle after the byte is taken.
- R4: After an addressed-style payload byte, the next byte is a header again. Bits 7..6 = 1x give a new row, 00 give an addressed column, and 01 give a streaming column.
- R5: In streaming, every byte (bit 7 set or not) is payload and is written at the current address. The column then advances by one, and it does not advance when no byte is taken.
- R6: In streaming, a step from column 30 goes to column 0 of the next row, and a step from column 30 of row 14 goes to row 0.
- R7: In the idle state, any byte that is not a row header is dropped without a write.
- R8: While frame_n is high, bytes are ignored and the decoder returns to idle, so the next frame must begin with a row header.
- R9: wr_en is high for exactly one cycle for each payload byte taken, and only in the cycle after a byte taken while frame_n is low.
- R10: Reset clears wr_en and the write outputs to zero and returns the decoder to idle, including in the middle of a stream.
- R11: A row header that arrives while a column header is expected replaces the pending row and plane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction active when low |
| byte_vld | input | 1 | Received byte valid, one cycle per byte |
| byte_in | input | 8 | Received byte |
| wr_en | output | 1 | Write strobe, one cycle per write |
| wr_row | output | 4 | Write row address |
| wr_col | output | 5 | Write column address (30 = row control) |
| wr_attr | output | 1 | Plane select: 0 code, 1 attribute |
| wr_data | output | 8 | Write data |

## Verification
The bench uses the default geometry of 15 rows and 31 columns. With these values a streaming run from column 29 reaches both the column wrap and the row wrap within a handful of bytes. It also crosses the control column 30, so the carry into the next row is checked at the real array edge. The short runs leave room for frame release, idle drops and a mid-stream reset in the same pass.

// File: rtl/osd_wcmd_pkg.sv
package osd_wcmd_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,  // waiting for the first row header
    S_HDR  = 2'd1,  // expecting a row or column header
    S_DAT  = 2'd2,  // one addressed payload byte expected
    S_STRM = 2'd3   // streaming payload with auto-step
  } fmt_st_e;

  typedef enum logic [1:0] {
    H_ROW   = 2'd0,
    H_COLAB = 2'd1,
    H_COLC  = 2'd2
  } hdr_kind_e;

  // Bits 7..6 of a header byte decide its kind.
  function automatic hdr_kind_e classify(input logic [1:0] top2);
    if (top2[1])      return H_ROW;
    else if (top2[0]) return H_COLC;
    else              return H_COLAB;
  endfunction

  // Increment that folds back to zero past the last index.
  function automatic logic [7:0] wrap_inc(input logic [7:0] v, input logic [7:0] last);
    return (v >= last) ? 8'd0 : 8'(v + 8'd1);
  endfunction

endpackage

// File: rtl/osd_fmt_fsm.sv
module osd_fmt_fsm
  import osd_wcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       byte_vld,
  input  logic [1:0] hdr_bits,
  output fmt_st_e    st,
  output logic       ev_ld_row,
  output logic       ev_ld_col,
  output logic       ev_wr,
  output logic       ev_step
);

  fmt_st_e   st_nx;
  hdr_kind_e kind;
  logic      take;

  assign take = byte_vld & ~frame_n;
  assign kind = classify(hdr_bits);

  always_comb begin
    st_nx     = st;
    ev_ld_row = 1'b0;
    ev_ld_col = 1'b0;
    ev_wr     = 1'b0;
    ev_step   = 1'b0;
    if (take) begin
      unique case (st)
        S_IDLE: begin
          if (kind == H_ROW) begin
            ev_ld_row = 1'b1;
            st_nx     = S_HDR;
          end
        end
        S_HDR: begin
          case (kind)
            H_ROW:   ev_ld_row = 1'b1;
            H_COLAB: begin ev_ld_col = 1'b1; st_nx = S_DAT;  end
            H_COLC:  begin ev_ld_col = 1'b1; st_nx = S_STRM; end
            default: st_nx = S_HDR;
          endcase
        end
        S_DAT: begin
          ev_wr = 1'b1;
          st_nx = S_HDR;
        end
        S_STRM: begin
          ev_wr   = 1'b1;
          ev_step = 1'b1;
        end
        default: st_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st <= S_IDLE;
    else if (frame_n) st <= S_IDLE;
    else             st <= st_nx;
  end

endmodule

// File: rtl/osd_addr_trk.sv
module osd_addr_trk
  import osd_wcmd_pkg::*;
#(
  parameter int NUM_ROWS = 15,
  parameter int NUM_COLS = 31,
  localparam int ROW_W = $clog2(NUM_ROWS),
  localparam int COL_W = $clog2(NUM_COLS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_ld_row,
  input  logic             ev_ld_col,
  input  logic             ev_step,
  input  logic [ROW_W-1:0] ld_row_val,
  input  logic             ld_attr_val,
  input  logic [COL_W-1:0] ld_col_val,
  output logic [ROW_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col,
  output logic             cur_attr
);

  localparam logic [7:0] ROW_LAST = 8'(NUM_ROWS - 1);
  localparam logic [7:0] COL_LAST = 8'(NUM_COLS - 1);

  logic [7:0] col_nx;
  logic [7:0] row_nx;
  logic       carry;

  always_comb begin
    col_nx = wrap_inc(8'(cur_col), COL_LAST);
    carry  = (col_nx == 8'd0);
    row_nx = carry ? wrap_inc(8'(cur_row), ROW_LAST) : 8'(cur_row);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_row  <= '0;
      cur_col  <= '0;
      cur_attr <= 1'b0;
    end else begin
      if (ev_ld_row) begin
        cur_row  <= ld_row_val;
        cur_attr <= ld_attr_val;
      end
      if (ev_ld_col) cur_col <= ld_col_val;
      if (ev_step) begin
        cur_col <= COL_W'(col_nx);
        cur_row <= ROW_W'(row_nx);
      end
    end
  end

endmodule

// File: rtl/osd_wcmd_dec.sv
module osd_wcmd_dec
  import osd_wcmd_pkg::*;
#(
  parameter int NUM_ROWS = 15,
  parameter int NUM_COLS = 31,
  localparam int ROW_W = $clog2(NUM_ROWS),
  localparam int COL_W = $clog2(NUM_COLS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  output logic             wr_en,
  output logic [ROW_W-1:0] wr_row,
  output logic [COL_W-1:0] wr_col,
  output logic             wr_attr,
  output logic [7:0]       wr_data
);

  fmt_st_e          st;
  logic             ev_ld_row, ev_ld_col, ev_wr, ev_step;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic             cur_attr;

  osd_fmt_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .byte_vld  (byte_vld),
    .hdr_bits  (byte_in[7:6]),
    .st        (st),
    .ev_ld_row (ev_ld_row),
    .ev_ld_col (ev_ld_col),
    .ev_wr     (ev_wr),
    .ev_step   (ev_step)
  );

  osd_addr_trk #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_ld_row   (ev_ld_row),
    .ev_ld_col   (ev_ld_col),
    .ev_step     (ev_step),
    .ld_row_val  (byte_in[ROW_W-1:0]),
    .ld_attr_val (byte_in[5]),
    .ld_col_val  (byte_in[COL_W-1:0]),
    .cur_row     (cur_row),
    .cur_col     (cur_col),
    .cur_attr    (cur_attr)
  );

  // Write port register: address captured before any step takes effect.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_attr <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= ev_wr;
      if (ev_wr) begin
        wr_row  <= cur_row;
        wr_col  <= cur_col;
        wr_attr <= cur_attr;
        wr_data <= byte_in;
      end
    end
  end

endmodule

// File: rtl/osd_wcmd_chk.sv
module osd_wcmd_chk
  import osd_wcmd_pkg::*;
#(
  parameter int NUM_ROWS = 15,
  parameter int NUM_COLS = 31,
  localparam int ROW_W = $clog2(NUM_ROWS),
  localparam int COL_W = $clog2(NUM_COLS)
)(
  input logic             clk,
  input logic             rst_n,
  input logic             frame_n,
  input logic             byte_vld,
  input logic             byte_b7,
  input logic             wr_en,
  input logic [ROW_W-1:0] wr_row,
  input logic [COL_W-1:0] wr_col,
  input fmt_st_e          st,
  input logic             ev_step,
  input logic [ROW_W-1:0] cur_row,
  input logic [COL_W-1:0] cur_col
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

  // R9
  wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(byte_vld) && !$past(frame_n)));

  // R5
  strm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STRM && byte_vld && !frame_n) |=> wr_en);

  // R7
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && byte_vld && !byte_b7) |=> !wr_en);

  // R8
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |=> (st == S_IDLE));

  // R3
  addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DAT && byte_vld && !frame_n) |=>
      (wr_en && wr_row == $past(cur_row) && wr_col == $past(cur_col)));

  // R6
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && cur_col == COL_LAST) |=> (cur_col == '0));

  // R6
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && cur_col == COL_LAST && cur_row == ROW_LAST) |=> (cur_row == '0));

endmodule

bind osd_wcmd_dec osd_wcmd_chk #(
  .NUM_ROWS (NUM_ROWS),
  .NUM_COLS (NUM_COLS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_n  (frame_n),
  .byte_vld (byte_vld),
  .byte_b7  (byte_in[7]),
  .wr_en    (wr_en),
  .wr_row   (wr_row),
  .wr_col   (wr_col),
  .st       (st),
  .ev_step  (ev_step),
  .cur_row  (cur_row),
  .cur_col  (cur_col)
);

// File: tb/sim_osd_wcmd_dec.sv
module sim_osd_wcmd_dec;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       wr_en;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic       wr_attr;
  logic [7:0] wr_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  osd_wcmd_dec u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .byte_vld(byte_vld),
    .byte_in(byte_in), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_attr(wr_attr), .wr_data(wr_data)
  );

  // {req[4], frame_n, byte[8], exp_wr, exp_row[4], exp_col[5], exp_attr}
  localparam int NV = 27;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  1'b0, 8'h83, 1'b0, 4'd0,  5'd0,  1'b0},  // R1 row 3, code plane
    {4'd2,  1'b0, 8'h05, 1'b0, 4'd0,  5'd0,  1'b0},  // R2 col 5 addressed
    {4'd3,  1'b0, 8'hA5, 1'b1, 4'd3,  5'd5,  1'b0},  // R3 payload
    {4'd4,  1'b0, 8'h07, 1'b0, 4'd0,  5'd0,  1'b0},  // R4 00 -> column
    {4'd3,  1'b0, 8'h3C, 1'b1, 4'd3,  5'd7,  1'b0},  // R3
    {4'd4,  1'b0, 8'hA2, 1'b0, 4'd0,  5'd0,  1'b0},  // R4 1x -> row 2 attr
    {4'd2,  1'b0, 8'h09, 1'b0, 4'd0,  5'd0,  1'b0},  // R2
    {4'd3,  1'b0, 8'h81, 1'b1, 4'd2,  5'd9,  1'b1},  // R3 bit7 payload
    {4'd4,  1'b0, 8'h5D, 1'b0, 4'd0,  5'd0,  1'b0},  // R4 01 -> stream col 29
    {4'd5,  1'b0, 8'h11, 1'b1, 4'd2,  5'd29, 1'b1},  // R5
    {4'd5,  1'b0, 8'hC5, 1'b1, 4'd2,  5'd30, 1'b1},  // R5 control column
    {4'd6,  1'b0, 8'h9E, 1'b1, 4'd3,  5'd0,  1'b1},  // R6 column wrap
    {4'd5,  1'b0, 8'h00, 1'b1, 4'd3,  5'd1,  1'b1},  // R5
    {4'd8,  1'b1, 8'h84, 1'b0, 4'd0,  5'd0,  1'b0},  // R8 released
    {4'd7,  1'b0, 8'h05, 1'b0, 4'd0,  5'd0,  1'b0},  // R7 column in idle
    {4'd7,  1'b0, 8'h12, 1'b0, 4'd0,  5'd0,  1'b0},  // R7
    {4'd1,  1'b0, 8'h8E, 1'b0, 4'd0,  5'd0,  1'b0},  // R1 row 14
    {4'd2,  1'b0, 8'h5E, 1'b0, 4'd0,  5'd0,  1'b0},  // R2 stream col 30
    {4'd5,  1'b0, 8'h77, 1'b1, 4'd14, 5'd30, 1'b0},  // R5
    {4'd6,  1'b0, 8'h78, 1'b1, 4'd0,  5'd0,  1'b0},  // R6 row wrap
    {4'd5,  1'b0, 8'h80, 1'b1, 4'd0,  5'd1,  1'b0},  // R5 no way back
    {4'd5,  1'b0, 8'h03, 1'b1, 4'd0,  5'd2,  1'b0},  // R5
    {4'd8,  1'b1, 8'h00, 1'b0, 4'd0,  5'd0,  1'b0},  // R8
    {4'd1,  1'b0, 8'h81, 1'b0, 4'd0,  5'd0,  1'b0},  // R1
    {4'd11, 1'b0, 8'h86, 1'b0, 4'd0,  5'd0,  1'b0},  // R11 row replaced
    {4'd2,  1'b0, 8'h00, 1'b0, 4'd0,  5'd0,  1'b0},  // R2
    {4'd11, 1'b0, 8'h55, 1'b1, 4'd6,  5'd0,  1'b0}   // R11
  };

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Drive one cycle of input, then return at the next falling edge.
  task automatic put(input logic fr, input logic [7:0] b, input logic v);
    @(negedge clk);
    frame_n  = fr;
    byte_in  = b;
    byte_vld = v;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic chk_wr(input int rq, input logic [3:0] r, input logic [4:0] c,
                        input logic a, input logic [7:0] d);
    chk(rq, "wr_en", 32'(wr_en), 32'd1);
    chk(rq, "row/col/attr/data", {14'd0, wr_row, wr_col, wr_attr, wr_data},
        {14'd0, r, c, a, d});
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(10, "wr_en in reset", 32'(wr_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(10, "outputs after reset", {18'd0, wr_en, wr_row, wr_col, wr_attr, wr_data}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      put(v[19], v[18:11], 1'b1);
      chk(int'(v[23:20]), $sformatf("vector %0d wr_en", i), 32'(wr_en), 32'(v[10]));
      if (v[10])
        chk(int'(v[23:20]), $sformatf("vector %0d fields", i),
            {14'd0, wr_row, wr_col, wr_attr, wr_data},
            {14'd0, v[9:6], v[5:1], v[0], v[18:11]});
    end

    // R9 strobe lasts one cycle
    @(negedge clk);
    chk(9, "strobe single cycle", 32'(wr_en), 32'd0);

    // R9 / R5: stream with no valid strobe does not write or step
    put(1'b1, 8'h00, 1'b0);
    put(1'b0, 8'h85, 1'b1);
    put(1'b0, 8'h43, 1'b1);
    for (int k = 0; k < 3; k++) begin
      put(1'b0, 8'h99, 1'b0);
      chk(9, "no write without valid", 32'(wr_en), 32'd0);
    end
    put(1'b0, 8'h99, 1'b1);
    chk_wr(5, 4'd5, 5'd3, 1'b0, 8'h99);  // R5 address unchanged by idle cycles
    put(1'b0, 8'h98, 1'b1);
    chk_wr(5, 4'd5, 5'd4, 1'b0, 8'h98);

    // R10 reset mid-stream returns to idle
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(10, "wr_en under reset", 32'(wr_en), 32'd0);
    rst_n = 1'b1;
    put(1'b0, 8'h42, 1'b1);
    chk(10, "payload after reset dropped", 32'(wr_en), 32'd0);
    put(1'b0, 8'h87, 1'b1);
    put(1'b0, 8'h01, 1'b1);
    put(1'b0, 8'hEE, 1'b1);
    chk_wr(10, 4'd7, 5'd1, 1'b0, 8'hEE);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

endmodule